// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes configuration words from a three-wire serial port (data, serial clock, load enable) and turns them into the divide settings of a frequency synthesizer. Bits arrive most significant first. Each rising edge of the serial clock shifts one bit into a 19-bit register. When load enable rises, the register contents are committed to one of two destination latch sets. The last bit shifted in (bit 0) selects which set: a reference set (reference divide ratio and prescaler select) or a main set (swallow count and main count).

All three serial pins are asynchronous to the system clock. They are synchronized into the system clock domain, and their edges are detected there. Each latch set drives a one-cycle update strobe. Downstream counters use it to reload at their next period boundary. A reference word that asks for a ratio below the legal minimum of 3 is discarded.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each rising edge of `serClk` the block samples `serData` and shifts it in, most significant bit first. Only the last 19 bits shifted before a load are used; earlier bits fall off the top.
- R2: A word with bit 0 = 1 is a reference word:
  - `refRatio` takes bits 14..1.
  - `pscSel` takes bit 15 (1 selects the 64/65 modulus, 0 selects 128/129).
  - Bits 18..16 have no effect.
- R3: A word with bit 0 = 0 is a main word: `swallowCnt` takes bits 7..1 and `mainCnt` takes bits 18..8.
- R4: A transfer happens only on a low-to-high change of `serLoadEn`.
  - The new latch values appear 4 system clock cycles after that pin change: two synchronizer stages, one edge-detect register and the latch.
  - A falling edge, or a level that is held, commits nothing.
  - `serClk` must be low whenever `serLoadEn` changes.
- R5: `refUpdate` and `mainUpdate` are each high for exactly one cycle, in the cycle the new values of their own set first appear. They are never high together. A load into one set leaves the other set unchanged.
- R6: Changes of `serData` while `serClk` stays low have no effect on the loaded word.
- R7: A reference word whose bits 14..1 hold a value below 3 is rejected. No output changes and no strobe is raised.
- R8: After reset all latch outputs are 0 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data, MSB first, asynchronous |
| serLoadEn | input | 1 | Load enable; rising edge commits the word |
| refRatio | output | 14 | Reference divide ratio (3..16383) |
| pscSel | output | 1 | Prescaler select: 1 = 64/65, 0 = 128/129 |
| swallowCnt | output | 7 | Swallow count (0..127) |
| mainCnt | output | 11 | Main counter divide ratio |
| refUpdate | output | 1 | One-cycle strobe when the reference set updates |
| mainUpdate | output | 1 | One-cycle strobe when the main set updates |

## Verification
The assertions check the following on every cycle:
- The two strobes are never high together.
- Each set's outputs stay stable in every cycle without its strobe.
- Every accepted reference ratio is at least 3.
- The serial clock is low whenever load enable changes level.

Only the bench scenarios can show the rest:
- The bit-field mapping of both word formats, including the ignored high bits of a reference word.
- The exact four-cycle commit latency.
- That only the last 19 bits are kept.
- That data glitches with the clock low are harmless.
- That out-of-range reference words are dropped without a strobe.

// File: rtl/serload_pkg.sv
package serload_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic shiftEn;  // one-cycle pulse: synchronized serial clock rose
    logic commit;   // one-cycle pulse: cycle after load-enable rose
  } ldrCtl_t;
endpackage

// File: rtl/serload_ctl.sv
module serload_ctl
  import serload_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    loadEn,
  output ldrCtl_t ctl,
  output logic    dataBit
);
  localparam int LAST = SYNC_STAGES - 1;

  // bit 2 = serial clock, bit 1 = data, bit 0 = load enable
  logic [2:0] syncPipe [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) syncPipe[0] <= '0;
    else       syncPipe[0] <= {serClk, serData, loadEn};
  end

  generate
    for (genvar gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncPipe[gi] <= '0;
        else       syncPipe[gi] <= syncPipe[gi-1];
      end
    end
  endgenerate

  logic sclkS, leS, sclkPrev, lePrev, commitQ;
  assign sclkS   = syncPipe[LAST][2];
  assign dataBit = syncPipe[LAST][1];
  assign leS     = syncPipe[LAST][0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      lePrev   <= 1'b0;
      commitQ  <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      lePrev   <= leS;
      commitQ  <= leS & ~lePrev;
    end
  end

  always_comb begin
    ctl.shiftEn = sclkS & ~sclkPrev;
    ctl.commit  = commitQ;
  end

  // R4: serial clock must be low whenever load enable changes level
  p_clk_low_le_r4: assert property (@(posedge clk) disable iff (!rstN)
    (leS != lePrev) |-> !sclkS);

endmodule

// File: rtl/serload_dp.sv
module serload_dp
  import serload_pkg::*;
#(
  parameter int SR_W    = 19,
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int MIN_REF = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldrCtl_t           ctl,
  input  logic              dataBit,
  output logic [REF_W-1:0]  refRatio,
  output logic              pscSel,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refUpd,
  output logic              mainUpd
);
  localparam int PSEL_BIT = REF_W + 1;
  localparam int MAIN_LSB = SWAL_W + 1;

  logic [SR_W-1:0]  shiftReg;
  logic [REF_W-1:0] candRatio;
  logic             isRefWord, refOk;

  always_ff @(posedge clk) begin
    if (!rstN)            shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {shiftReg[SR_W-2:0], dataBit};
  end

  assign isRefWord = shiftReg[0];
  assign candRatio = shiftReg[REF_W:1];
  assign refOk     = (candRatio >= REF_W'(MIN_REF));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refRatio   <= '0;
      pscSel     <= 1'b0;
      swallowCnt <= '0;
      mainCnt    <= '0;
      refUpd     <= 1'b0;
      mainUpd    <= 1'b0;
    end else begin
      refUpd  <= 1'b0;
      mainUpd <= 1'b0;
      if (ctl.commit) begin
        if (isRefWord) begin
          if (refOk) begin
            refRatio <= candRatio;
            pscSel   <= shiftReg[PSEL_BIT];
            refUpd   <= 1'b1;
          end
        end else begin
          swallowCnt <= shiftReg[SWAL_W:1];
          mainCnt    <= shiftReg[SR_W-1:MAIN_LSB];
          mainUpd    <= 1'b1;
        end
      end
    end
  end

  // R5: the two strobes never coincide
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(refUpd && mainUpd));

  // R5: reference set only moves together with its strobe
  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !refUpd |-> ($stable(refRatio) && $stable(pscSel)));

  // R5: main set only moves together with its strobe
  p_main_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !mainUpd |-> ($stable(swallowCnt) && $stable(mainCnt)));

  // R7: an accepted reference ratio is never below the minimum
  p_ref_min_r7: assert property (@(posedge clk) disable iff (!rstN)
    refUpd |-> (refRatio >= REF_W'(MIN_REF)));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serload_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SR_W        = 19,
  parameter int REF_W       = 14,
  parameter int SWAL_W      = 7,
  parameter int MAIN_W      = 11,
  parameter int MIN_REF     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoadEn,
  output logic [REF_W-1:0]  refRatio,
  output logic              pscSel,
  output logic [SWAL_W-1:0] swallowCnt,
  output logic [MAIN_W-1:0] mainCnt,
  output logic              refUpdate,
  output logic              mainUpdate
);
  ldrCtl_t ctlS;
  logic    dataBitS;

  serload_ctl #(.SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .loadEn  (serLoadEn),
    .ctl     (ctlS),
    .dataBit (dataBitS)
  );

  serload_dp #(
    .SR_W   (SR_W),
    .REF_W  (REF_W),
    .SWAL_W (SWAL_W),
    .MAIN_W (MAIN_W),
    .MIN_REF(MIN_REF)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctlS),
    .dataBit    (dataBitS),
    .refRatio   (refRatio),
    .pscSel     (pscSel),
    .swallowCnt (swallowCnt),
    .mainCnt    (mainCnt),
    .refUpd     (refUpdate),
    .mainUpd    (mainUpdate)
  );
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  localparam int HALF = 13;  // serial half period in system clocks (52 ns)
  localparam int LAT  = 4;   // R4 commit latency

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoadEn = 1'b0;
  logic [13:0] refRatio;
  logic        pscSel;
  logic [6:0]  swallowCnt;
  logic [10:0] mainCnt;
  logic        refUpdate, mainUpdate;

  always #2 clk = ~clk;  // 250 MHz

  serial_cfg_loader dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoadEn(serLoadEn), .refRatio(refRatio), .pscSel(pscSel),
    .swallowCnt(swallowCnt), .mainCnt(mainCnt),
    .refUpdate(refUpdate), .mainUpdate(mainUpdate)
  );

  typedef struct {
    bit isRef;
    int due;
    int r, p, s, m;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  int refM = 0, pscM = 0, swM = 0, mnM = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops an expected item whenever a strobe is seen
  always @(negedge clk) begin
    if (rstN && (refUpdate || mainUpdate)) begin
      chk(!(refUpdate && mainUpdate), "R5", "both strobes high", 1, 0);
      if (q.size() == 0) begin
        chk(1'b0, "R4", "unexpected strobe", 1, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(refUpdate == it.isRef, "R5", "strobe kind (1=ref)", int'(refUpdate), int'(it.isRef));
        chk(cyc == it.due, "R4", "commit latency cycle", cyc, it.due);
        chk(int'(refRatio) == it.r, "R2", "refRatio", int'(refRatio), it.r);
        chk(int'(pscSel) == it.p, "R2", "pscSel", int'(pscSel), it.p);
        chk(int'(swallowCnt) == it.s, "R3", "swallowCnt", int'(swallowCnt), it.s);
        chk(int'(mainCnt) == it.m, "R3", "mainCnt", int'(mainCnt), it.m);
      end
    end
  end

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  // R1: MSB first, sampled on serial clock rise; glitch option for R6
  task automatic sendBits(input logic [31:0] w, input int nbits, input bit glitch);
    for (int i = nbits - 1; i >= 0; i--) begin
      if (glitch) begin
        for (int k = 0; k < 4; k++) begin
          serData = ~serData;
          @(negedge clk);
        end
      end
      serData = w[i];
      halfWait();
      serClk = 1'b1;
      halfWait();
      serClk = 1'b0;
    end
  endtask

  task automatic loadWord(input logic [31:0] w, input int nbits, input bit glitch,
                          input string tag);
    logic [18:0] v;
    bit push;
    item_t it;
    v = w[18:0];
    sendBits(w, nbits, glitch);
    push = 1'b1;
    if (v[0]) begin
      if (int'(v[14:1]) >= 3) begin
        refM = int'(v[14:1]);
        pscM = int'(v[15]);
      end else begin
        push = 1'b0;  // R7 rejected
      end
    end else begin
      swM = int'(v[7:1]);
      mnM = int'(v[18:8]);
    end
    halfWait();
    serLoadEn = 1'b1;
    if (push) begin
      it.isRef = v[0];
      it.due = cyc + LAT;
      it.r = refM; it.p = pscM; it.s = swM; it.m = mnM;
      q.push_back(it);
    end
    halfWait();
    serLoadEn = 1'b0;
    halfWait();
    chk(q.size() == 0, tag, "pending expected strobes", q.size(), 0);
    chk(int'(refRatio) == refM && int'(pscSel) == pscM, tag, "ref set after load",
        int'(refRatio), refM);
    chk(int'(swallowCnt) == swM && int'(mainCnt) == mnM, tag, "main set after load",
        int'(mainCnt), mnM);
  endtask

  function automatic logic [31:0] refWord(input int hi, input int psc, input int r);
    return (32'(hi) << 16) | (32'(psc) << 15) | (32'(r) << 1) | 32'd1;
  endfunction

  function automatic logic [31:0] mainWord(input int b, input int a);
    return (32'(b) << 8) | (32'(a) << 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(refRatio == '0 && pscSel == 1'b0, "R8", "ref set after reset", int'(refRatio), 0);
    chk(swallowCnt == '0 && mainCnt == '0, "R8", "main set after reset", int'(mainCnt), 0);
    chk(!refUpdate && !mainUpdate, "R8", "strobes after reset",
        int'(refUpdate) + int'(mainUpdate), 0);

    loadWord(mainWord(300, 17), 19, 1'b0, "R3");
    loadWord(refWord(5, 1, 1000), 19, 1'b0, "R2");
    loadWord(refWord(2, 1, 1000), 19, 1'b0, "R2");   // high bits differ, no effect
    loadWord(refWord(0, 0, 3), 19, 1'b0, "R2");      // minimum ratio
    loadWord(refWord(7, 1, 16383), 19, 1'b0, "R2");  // maximum ratio
    loadWord(refWord(0, 0, 2), 19, 1'b0, "R7");      // rejected
    loadWord(refWord(3, 1, 0), 19, 1'b0, "R7");      // rejected
    loadWord(mainWord(2047, 127), 19, 1'b0, "R3");
    loadWord(mainWord(3, 0), 19, 1'b0, "R5");
    // R1: three junk leading bits drop off the top
    loadWord((32'h7 << 19) | mainWord(1234, 85), 22, 1'b0, "R1");
    // R6: data toggles with clock low
    loadWord(refWord(0, 0, 4321), 19, 1'b1, "R6");

    // R4: a lone falling edge and a held level commit nothing
    serLoadEn = 1'b1;
    begin
      item_t it;
      it.isRef = 1'b1; it.due = cyc + LAT;
      it.r = refM; it.p = pscM; it.s = swM; it.m = mnM;
      q.push_back(it);  // re-commit of the same word on this rise
    end
    repeat (40) @(negedge clk);
    serLoadEn = 1'b0;
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R4", "strobes after held level and fall", q.size(), 0);
    finishRun();
  end
endmodule